// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the send side of a network adapter. Outgoing packets live in host memory and are described by a circular ring of descriptors. Software owns the tail index and the engine owns the head index. To queue a packet, software writes the descriptor at tail and then moves tail forward. That register write wakes the engine.

The engine then works through every descriptor from head up to tail. For each one it reads the descriptor, reads the packet buffer one memory word at a time through a one-word staging register, and presents the bytes on a valid/ready byte stream that marks the final byte. After the last byte has been accepted, it writes the descriptor back with its sent flag raised, advances head and, if enabled, raises an interrupt. When interrupts are off, software polls the head index.

Host memory is reached through a request/response port with one transaction in flight. A read request is answered later by a single response beat. A write is complete once its request is accepted.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset, head and tail are 0, the ring reads empty and not full, and no memory request, stream byte or interrupt is active.
- R2: The ring has N = 2^RING_BITS slots. `ring_empty` is high exactly when head equals tail, and the engine issues no memory request while it is high. `ring_full` is high exactly when head equals (tail+1) mod N.
- R3: A pulse on `tail_wr` loads `tail_wdata` into tail and starts processing whenever head differs from tail. Descriptor i occupies two 32-bit words at `ring_base + 8*i`: word 0 is the byte address of the word-aligned buffer, and word 1 holds the length in bits 15:0 and the sent flag in bit 31.
- R4: Exactly length bytes leave on the stream, in buffer order. Byte k of a buffer word sits in bits 8k+7:8k. `tx_last` is high on the final byte only.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: After the final byte has been accepted, and not before, the engine writes word 1 of the descriptor (address `ring_base + 8*head + 4`) with bit 31 set and the length bits unchanged.
- R7: Head advances by one, modulo N, in the cycle the write-back is accepted, and never moves in any other way.
- R8: With `irq_en` high, `irq` rises at each head advance and stays high until `irq_ack`. If a completion and an acknowledge fall in the same cycle, the completion wins.
- R9: With `irq_en` low, `irq` never rises, while head still advances so that polling sees each completion.
- R10: A descriptor with length 0 sends no bytes but is still written back, and head still advances.
- R11: Descriptors are served strictly in ring order, and slot N-1 is followed by slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of descriptor slot 0 |
| tail_wr | input | 1 | Tail register write strobe (doorbell) |
| tail_wdata | input | RING_BITS | New tail value |
| head_o | output | RING_BITS | Current head index |
| tail_o | output | RING_BITS | Current tail index |
| ring_empty | output | 1 | Head equals tail |
| ring_full | output | 1 | Head equals tail plus one |
| irq_en | input | 1 | Completion interrupt enable |
| irq_ack | input | 1 | Clears the interrupt |
| irq | output | 1 | Completion interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | MEM_W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | MEM_W | Read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Stream sink ready |

## Verification
A completion that sets the interrupt can land in the same cycle as a software acknowledge that clears it. The bench provokes this by raising `irq_ack` at random on every cycle while packets of random length drain under random memory and stream back-pressure, and by toggling `irq_en` between batches. Every cycle, it predicts `irq` from the previous cycle's head step, enable and acknowledge, with the set taking priority, and compares the prediction with the port.

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int RING_BITS = 3,
  parameter int ADDR_W    = 32,
  parameter int MEM_W     = 32,
  parameter int LEN_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    ring_base,
  input  logic                 tail_wr,
  input  logic [RING_BITS-1:0] tail_wdata,
  output logic [RING_BITS-1:0] head_o,
  output logic [RING_BITS-1:0] tail_o,
  output logic                 ring_empty,
  output logic                 ring_full,
  input  logic                 irq_en,
  input  logic                 irq_ack,
  output logic                 irq,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [MEM_W-1:0]     mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [MEM_W-1:0]     mem_rsp_data,
  output logic [7:0]           tx_data,
  output logic                 tx_valid,
  output logic                 tx_last,
  input  logic                 tx_ready
);

  localparam int BYTES      = MEM_W / 8;
  localparam int IDX_W      = $clog2(BYTES);
  localparam int DESC_BYTES = 2 * BYTES;

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D0W, S_D1, S_D1W, S_BUF, S_BUFW, S_SEND, S_WB
  } st_t;

  st_t                  st;
  logic [RING_BITS-1:0] head, tail;
  logic [ADDR_W-1:0]    buf_addr;
  logic [LEN_W-1:0]     len_left;
  logic [MEM_W-1:0]     desc_w1;
  logic [MEM_W-1:0]     word_q;
  logic [IDX_W-1:0]     idx;

  logic [ADDR_W-1:0] desc_addr;
  logic              req_fire, tx_fire, done;

  assign desc_addr  = ring_base + ADDR_W'(head) * ADDR_W'(DESC_BYTES);
  assign head_o     = head;
  assign tail_o     = tail;
  assign ring_empty = (head == tail);
  assign ring_full  = (head == RING_BITS'(tail + 1'b1));

  assign mem_req_valid = (st == S_D0) || (st == S_D1) || (st == S_BUF) || (st == S_WB);
  assign mem_req_we    = (st == S_WB);
  assign mem_req_wdata = desc_w1 | (MEM_W'(1) << (MEM_W - 1));

  always_comb begin
    unique case (st)
      S_D0:        mem_req_addr = desc_addr;
      S_D1, S_WB:  mem_req_addr = desc_addr + ADDR_W'(BYTES);
      S_BUF:       mem_req_addr = buf_addr;
      default:     mem_req_addr = '0;
    endcase
  end

  assign tx_valid = (st == S_SEND);
  assign tx_data  = word_q[{idx, 3'b000} +: 8];
  assign tx_last  = tx_valid && (len_left == LEN_W'(1));

  assign req_fire = mem_req_valid && mem_req_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign done     = (st == S_WB) && req_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail <= '0;
    else if (tail_wr) tail <= tail_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else if (done && irq_en) irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      head     <= '0;
      buf_addr <= '0;
      len_left <= '0;
      desc_w1  <= '0;
      word_q   <= '0;
      idx      <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (head != tail) st <= S_D0;
        S_D0:   if (req_fire) st <= S_D0W;
        S_D0W:  if (mem_rsp_valid) begin
                  buf_addr <= ADDR_W'(mem_rsp_data);
                  st       <= S_D1;
                end
        S_D1:   if (req_fire) st <= S_D1W;
        S_D1W:  if (mem_rsp_valid) begin
                  desc_w1  <= mem_rsp_data;
                  len_left <= mem_rsp_data[LEN_W-1:0];
                  idx      <= '0;
                  st       <= (mem_rsp_data[LEN_W-1:0] == '0) ? S_WB : S_BUF;
                end
        S_BUF:  if (req_fire) st <= S_BUFW;
        S_BUFW: if (mem_rsp_valid) begin
                  word_q <= mem_rsp_data;
                  st     <= S_SEND;
                end
        S_SEND: if (tx_fire) begin
                  len_left <= len_left - 1'b1;
                  idx      <= idx + 1'b1;
                  if (len_left == LEN_W'(1)) begin
                    st <= S_WB;
                  end else if (idx == IDX_W'(BYTES - 1)) begin
                    buf_addr <= buf_addr + ADDR_W'(BYTES);
                    st       <= S_BUF;
                  end
                end
        S_WB:   if (req_fire) begin
                  head <= head + 1'b1;
                  st   <= S_IDLE;
                end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_ring_dma_chk.sv
module tx_ring_dma_chk #(
  parameter int RING_BITS = 3,
  parameter int ADDR_W    = 32,
  parameter int MEM_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [RING_BITS-1:0] head_o,
  input logic                 ring_empty,
  input logic                 irq,
  input logic                 irq_en,
  input logic                 irq_ack,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_data,
  input logic                 tx_last,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_we,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic [MEM_W-1:0]     mem_req_wdata
);

  a_r5_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  a_r4_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r6_wb_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[MEM_W-1]);

  a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (head_o == $past(head_o) || head_o == RING_BITS'($past(head_o) + 1'b1)));

  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq) |=> !irq);

  a_r2_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ring_empty |-> !mem_req_valid);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

endmodule

bind tx_ring_dma tx_ring_dma_chk #(.RING_BITS(RING_BITS), .ADDR_W(ADDR_W), .MEM_W(MEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_o(head_o), .ring_empty(ring_empty), .irq(irq),
  .irq_en(irq_en), .irq_ack(irq_ack), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_tx_ring_dma.sv
`timescale 1ns/1ps
module test_tx_ring_dma;
  localparam int RB = 3;
  localparam int N  = 1 << RB;
  localparam logic [31:0] RING_BASE  = 32'h0000_0100;
  localparam int          BUF_BASE   = 32'h1000;
  localparam int          BUF_STRIDE = 32'h200;

  logic clk = 0, rst_n = 0;
  logic [31:0] ring_base = RING_BASE;
  logic tail_wr = 0;
  logic [RB-1:0] tail_wdata = '0;
  logic [RB-1:0] head_o, tail_o;
  logic ring_empty, ring_full;
  logic irq_en = 0, irq_ack = 0, irq;
  logic mem_req_valid, mem_req_ready = 0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready = 0;

  tx_ring_dma #(.RING_BITS(RB)) i_tx_ring_dma (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tail_wr(tail_wr), .tail_wdata(tail_wdata),
    .head_o(head_o), .tail_o(tail_o), .ring_empty(ring_empty), .ring_full(ring_full),
    .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [0:4095];
  byte unsigned exp_q[$];
  bit exp_last_q[$];
  int pkt_len [N];
  bit used [N];
  int sw_tail = 0, exp_head = 0, bytes_cur = 0;
  bit irq_mode = 0, ack_mode = 0, force_ack = 0, hold = 0, running = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // memory, sink and per-cycle port model
  initial begin
    int cnt;
    logic [31:0] raddr;
    logic [RB-1:0] head_p;
    bit irq_p, ack_p, en_p, val_p, rdy_p, last_p;
    logic [7:0] data_p;
    cnt = 0; raddr = 0;
    wait (running);
    head_p = head_o; irq_p = irq; ack_p = 0; en_p = 0; val_p = 0; rdy_p = 0; last_p = 0; data_p = 0;
    forever begin
      @(negedge clk);
      chk(head_o == head_p || head_o == RB'(head_p + 1'b1), "R7", "head step", head_o, head_p);
      chk(irq == (((head_o != head_p) && en_p) || (irq_p && !ack_p)), "R8", "irq state", irq,
          ((head_o != head_p) && en_p) || (irq_p && !ack_p));
      if (!en_p && !irq_p) chk(!irq, "R9", "irq masked", irq, 0);
      if (val_p && !rdy_p)
        chk(tx_valid && tx_data == data_p && tx_last == last_p, "R5", "stall hold",
            {tx_valid, tx_last, tx_data}, {1'b1, last_p, data_p});
      chk(ring_empty == (head_o == tail_o) && ring_full == (head_o == RB'(tail_o + 1'b1)),
          "R2", "empty/full flags", {ring_empty, ring_full},
          {head_o == tail_o, head_o == RB'(tail_o + 1'b1)});
      if (ring_empty) chk(!mem_req_valid, "R2", "request while empty", mem_req_valid, 0);

      mem_rsp_valid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem[raddr[13:2]];
        end
      end

      mem_req_ready = ($urandom % 4) != 0;
      tx_ready      = hold ? 1'b0 : (($urandom % 3) != 0);
      irq_ack       = force_ack | (ack_mode && ($urandom % 5 == 0));
      irq_en        = irq_mode;

      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          chk(mem_req_addr == RING_BASE + 32'(8 * exp_head + 4), "R6", "writeback address",
              mem_req_addr, RING_BASE + 32'(8 * exp_head + 4));
          chk(mem_req_wdata == (32'h8000_0000 | 32'(pkt_len[exp_head])), "R6", "writeback data",
              mem_req_wdata, 32'h8000_0000 | 32'(pkt_len[exp_head]));
          chk(bytes_cur == pkt_len[exp_head], "R6", "writeback after last byte",
              bytes_cur, pkt_len[exp_head]);
          mem[mem_req_addr[13:2]] = mem_req_wdata;
          exp_head  = (exp_head + 1) % N;
          bytes_cur = 0;
        end else begin
          if (mem_req_addr >= RING_BASE && mem_req_addr < RING_BASE + 32'(8 * N))
            chk((mem_req_addr - RING_BASE) / 8 == 32'(exp_head), "R11", "descriptor order",
                (mem_req_addr - RING_BASE) / 8, exp_head);
          raddr = mem_req_addr;
          cnt   = 1 + int'($urandom % 3);
        end
      end

      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected byte", tx_data, 0);
        end else begin
          byte unsigned eb;
          bit el;
          eb = exp_q.pop_front();
          el = exp_last_q.pop_front();
          chk(tx_data == eb, "R4", "stream byte", tx_data, eb);
          chk(tx_last == el, "R4", "last flag", tx_last, el);
          bytes_cur++;
        end
      end

      head_p = head_o; irq_p = irq; ack_p = irq_ack; en_p = irq_en;
      val_p = tx_valid; rdy_p = tx_ready; data_p = tx_data; last_p = tx_last;
    end
  end

  task automatic enqueue(input int len);
    int t, d, b;
    while (((sw_tail + 1) % N) == int'(head_o)) @(negedge clk);
    t = sw_tail;
    d = (int'(RING_BASE) + 8 * t) / 4;
    b = BUF_BASE + t * BUF_STRIDE;
    mem[d]     = 32'(b);
    mem[d + 1] = 32'(len);
    for (int i = 0; i < len; i++) begin
      byte unsigned v;
      v = 8'($urandom);
      mem[b / 4 + i / 4][8 * (i % 4) +: 8] = v;
      exp_q.push_back(v);
      exp_last_q.push_back(i == len - 1);
    end
    pkt_len[t] = len;
    used[t]    = 1;
    sw_tail    = (t + 1) % N;
    @(negedge clk);
    tail_wr = 1; tail_wdata = RB'(sw_tail);
    @(negedge clk);
    tail_wr = 0;
    chk(tail_o == RB'(sw_tail), "R3", "tail write", tail_o, sw_tail);
  endtask

  task automatic drain();
    while (int'(head_o) != sw_tail) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int h0;
    void'($urandom(32'd7041));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(head_o == 0 && tail_o == 0, "R1", "reset indices", {head_o, tail_o}, 0);
    chk(ring_empty && !ring_full, "R1", "reset flags", {ring_empty, ring_full}, 2'b10);
    chk(!mem_req_valid && !tx_valid && !irq, "R1", "reset outputs",
        {mem_req_valid, tx_valid, irq}, 0);
    running = 1;
    @(negedge clk);

    // directed: interrupt raised and held, then cleared
    irq_mode = 1;
    enqueue(5);
    drain();
    chk(irq == 1, "R8", "irq after completion", irq, 1);
    force_ack = 1; @(negedge clk); force_ack = 0; @(negedge clk);
    chk(irq == 0, "R8", "irq cleared by ack", irq, 0);

    // zero-length descriptor
    h0 = int'(head_o);
    enqueue(0);
    drain();
    chk(int'(head_o) == (h0 + 1) % N, "R10", "head after empty packet", head_o, (h0 + 1) % N);
    chk(mem[(int'(RING_BASE) + 8 * h0) / 4 + 1] == 32'h8000_0000, "R10", "empty packet flag",
        mem[(int'(RING_BASE) + 8 * h0) / 4 + 1], 32'h8000_0000);

    // polling mode
    irq_mode = 0; force_ack = 1; @(negedge clk); force_ack = 0;
    h0 = int'(head_o);
    enqueue(4); enqueue(9); enqueue(1);
    drain();
    chk(irq == 0, "R9", "no irq when disabled", irq, 0);
    chk(int'(head_o) == (h0 + 3) % N, "R9", "head advanced for polling", head_o, (h0 + 3) % N);

    // fill the ring while the stream is stalled
    hold = 1;
    for (int i = 0; i < N - 1; i++) enqueue(6);
    @(negedge clk);
    chk(ring_full == 1, "R2", "ring full", ring_full, 1);
    hold = 0;
    drain();
    chk(ring_empty == 1, "R2", "ring empty after drain", ring_empty, 1);

    // random traffic with racing acknowledges
    ack_mode = 1;
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0) irq_mode = $urandom % 2;
      enqueue((n % 13 == 0) ? int'($urandom % 300) : int'($urandom % 41));
      if ($urandom % 4 == 0) repeat ($urandom % 20) @(negedge clk);
    end
    drain();
    ack_mode = 0;

    chk(exp_q.size() == 0, "R4", "all bytes delivered", exp_q.size(), 0);
    chk(int'(head_o) == sw_tail, "R11", "head caught up with tail", head_o, sw_tail);
    for (int s = 0; s < N; s++)
      if (used[s])
        chk(mem[(int'(RING_BASE) + 8 * s) / 4 + 1] == (32'h8000_0000 | 32'(pkt_len[s])), "R6",
            "final sent flag", mem[(int'(RING_BASE) + 8 * s) / 4 + 1],
            32'h8000_0000 | 32'(pkt_len[s]));
    finish_run();
  end
endmodule